// File: doc/BRIEF.md
# Reseed Scheduler with Request Timeout and Hash-Count Refresh

This block decides when a masking pseudo-random generator must be given fresh seed material. It drives a single request line toward an external entropy source and waits for that source to acknowledge. A request is started by a manual pulse, or by a counter of finished hash operations once that counter reaches a programmable threshold. Each completed reseed is reported with a one-cycle pulse.

While a request is outstanding, a prescaled watchdog runs. A cycle counter produces a tick every `prescale + 1` cycles, and each tick advances a wait counter. When the wait counter reaches the programmed limit, the block gives up and enters a sticky error state. It stays there until an explicit error-clear pulse arrives. A limit of zero turns the watchdog off. The limit is only taken from its input while no request is pending, so software can change it at any time without disturbing a request that is in flight.

The hash counter counts completion pulses from the hashing core. A threshold of zero disables count-triggered refresh, and in that case the counter goes back to zero only on a clear command. Any trigger that arrives while a request is already pending is folded into that request.

Top module: `reseed_sched`

## Requirements
- R1: After reset, `ent_req_o`, `timeout_err_o` and `reseed_done_o` are 0 and `hash_cnt_o` is 0.
- R2: A `manual_req_i` pulse sampled while the block is idle raises `ent_req_o` at the next clock edge. `ent_req_o` then stays high until an acknowledge or a timeout.
- R3: `ent_ack_i` sampled while `ent_req_o` is high lowers `ent_req_o` at the next edge. At that same edge `reseed_done_o` goes high for exactly one cycle. `ent_ack_i` sampled while no request is pending has no effect on any output.
- R4: With a nonzero limit L and prescale value P, the wait counter advances once every P+1 cycles of a pending request. `ent_req_o` stays high for exactly L*(P+1)+1 cycles. At the edge where it falls, `timeout_err_o` rises. The two outputs are never high together.
- R5: A wait limit of 0 disables the timeout: a request waits for the acknowledge indefinitely.
- R6: The wait limit is captured from `wait_limit_i` only while no request is pending. A change made during a pending request affects only later requests.
- R7: Whenever the hash count is greater than or equal to a nonzero `threshold_i` and the block is not in error, the count returns to 0 at the next edge. If the block is idle, a request is issued at that same edge. This includes the case where the threshold is lowered below an existing count.
- R8: With `threshold_i` = 0, hash pulses only increment the count and never issue a request. A `cnt_clr_i` pulse sets `hash_cnt_o` to 0 at the next edge.
- R9: `timeout_err_o` stays high, and acknowledges and triggers are ignored, until an `err_clr_i` pulse. At the edge after that pulse the block returns to idle.
- R10: Manual or count triggers that arrive while a request is pending do not cause a second request after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 10 | Tick period minus one, in cycles |
| wait_limit_i | input | 16 | Timeout in ticks; 0 disables the timeout |
| threshold_i | input | 10 | Hash count that forces a reseed; 0 disables it |
| hash_done_i | input | 1 | One-cycle pulse per completed hash |
| manual_req_i | input | 1 | One-cycle manual reseed command |
| cnt_clr_i | input | 1 | One-cycle hash counter clear command |
| err_clr_i | input | 1 | One-cycle pulse that leaves the error state |
| ent_ack_i | input | 1 | Acknowledge from the entropy source |
| ent_req_o | output | 1 | Request to the entropy source |
| timeout_err_o | output | 1 | Sticky timeout error |
| hash_cnt_o | output | 10 | Current hash count |
| reseed_done_o | output | 1 | One-cycle pulse when a reseed completes |

## Verification
The timeout is run with three prescale and limit pairs: (2,3), (0,1) and (0,4). Each pair has a different expected request length, so an off-by-one in the tick period, in the wait counter or in the compare would each show up as an event in the wrong cycle. A zero limit held for 150 cycles separates "disabled" from "very long". Changing the limit in the middle of a request, and then checking the following request, shows whether the limit is captured at issue time or read live.

The hash counter is exercised three ways. First, it counts up to the threshold. Second, it is loaded with the threshold at zero and then the threshold is lowered below the count, which distinguishes a greater-or-equal compare from an equality compare. Third, it reaches the threshold while a request is pending, which shows whether that trigger is merged or replayed afterwards.

// File: rtl/reseed_pkg.sv
package reseed_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FAIL = 2'd2
  } sched_state_e;
endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
  parameter int unsigned PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  logic [PW-1:0] cyc_q;

  function automatic logic period_hit(input logic [PW-1:0] c, input logic [PW-1:0] p);
    return c == p;
  endfunction

  assign tick_o = run_i && period_hit(cyc_q, period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= '0;
    else if (!run_i) cyc_q <= '0;
    else if (tick_o) cyc_q <= '0;
    else             cyc_q <= cyc_q + 1'b1;
  end
endmodule

// File: rtl/rs_wait_timer.sv
module rs_wait_timer #(
  parameter int unsigned WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pending_i,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [WW-1:0] limit_i,
  output logic          expire_o,
  output logic [WW-1:0] limit_q_o,
  output logic [WW-1:0] wait_q_o
);
  logic [WW-1:0] lim_q, wait_q;

  function automatic logic limit_reached(input logic [WW-1:0] w, input logic [WW-1:0] l);
    return (l != '0) && (w >= l);
  endfunction

  // limit is only sampled while nothing is pending: updates are deferred
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lim_q <= '0;
    else if (!pending_i) lim_q <= limit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wait_q <= '0;
    else if (clr_i)                          wait_q <= '0;
    else if (pending_i && tick_i && wait_q != '1) wait_q <= wait_q + 1'b1;
  end

  assign expire_o  = pending_i && limit_reached(wait_q, lim_q);
  assign limit_q_o = lim_q;
  assign wait_q_o  = wait_q;
endmodule

// File: rtl/rs_hash_counter.sv
module rs_hash_counter #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          clr_i,
  input  logic          consume_i,
  input  logic [CW-1:0] thresh_i,
  output logic [CW-1:0] cnt_o,
  output logic          trig_o
);
  logic [CW-1:0] cnt_q;

  function automatic logic count_due(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return (t != '0) && (c >= t);
  endfunction

  assign trig_o = count_due(cnt_q, thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (consume_i && trig_o)      cnt_q <= '0;
    else if (done_i && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/reseed_sched.sv
module reseed_sched #(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned WAIT_W  = 16,
  parameter int unsigned CNT_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] prescale_i,
  input  logic [WAIT_W-1:0]  wait_limit_i,
  input  logic [CNT_W-1:0]   threshold_i,
  input  logic               hash_done_i,
  input  logic               manual_req_i,
  input  logic               cnt_clr_i,
  input  logic               err_clr_i,
  input  logic               ent_ack_i,
  output logic               ent_req_o,
  output logic               timeout_err_o,
  output logic [CNT_W-1:0]   hash_cnt_o,
  output logic               reseed_done_o
);
  import reseed_pkg::*;

  sched_state_e state_q, state_d;
  logic done_q;

  // named internal events
  logic pending, in_fail, cnt_trig, any_trig, issue, ack_take, tick, expire;
  logic [WAIT_W-1:0] lim_now, wait_now;

  assign pending  = (state_q == ST_WAIT);
  assign in_fail  = (state_q == ST_FAIL);
  assign any_trig = manual_req_i | cnt_trig;
  assign issue    = (state_q == ST_IDLE) && any_trig;
  assign ack_take = pending && ent_ack_i;

  rs_tick_gen #(.PW(PRESC_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pending),
    .period_i (prescale_i),
    .tick_o   (tick)
  );

  rs_wait_timer #(.WW(WAIT_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .clr_i     (issue | ack_take),
    .tick_i    (tick),
    .limit_i   (wait_limit_i),
    .expire_o  (expire),
    .limit_q_o (lim_now),
    .wait_q_o  (wait_now)
  );

  rs_hash_counter #(.CW(CNT_W)) u_hcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (hash_done_i),
    .clr_i     (cnt_clr_i),
    .consume_i (!in_fail),
    .thresh_i  (threshold_i),
    .cnt_o     (hash_cnt_o),
    .trig_o    (cnt_trig)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (any_trig)  state_d = ST_WAIT;
      ST_WAIT: begin
        if (ent_ack_i)        state_d = ST_IDLE;
        else if (expire)      state_d = ST_FAIL;
      end
      ST_FAIL: if (err_clr_i) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ack_take;
    end
  end

  assign ent_req_o     = pending;
  assign timeout_err_o = in_fail;
  assign reseed_done_o = done_q;
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int unsigned WAIT_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ent_req_o,
  input logic              ent_ack_i,
  input logic              timeout_err_o,
  input logic              reseed_done_o,
  input logic              err_clr_i,
  input logic              cnt_clr_i,
  input logic [CNT_W-1:0]  hash_cnt_o,
  input logic [WAIT_W-1:0] lim_now,
  input logic [WAIT_W-1:0] wait_now
);
  p_req_err_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ent_req_o && timeout_err_o));

  p_wait_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_req_o && lim_now != '0) |-> (wait_now <= lim_now));

  p_done_follows_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_done_o |-> $past(ent_req_o && ent_ack_i));

  p_no_timeout_unlimited_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_err_o) |-> ($past(lim_now) != '0));

  p_limit_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_req_o && $past(ent_req_o)) |-> $stable(lim_now));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_err_o && !err_clr_i) |=> timeout_err_o);

  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (hash_cnt_o == '0));
endmodule

bind reseed_sched rs_sched_chk #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ent_req_o     (ent_req_o),
  .ent_ack_i     (ent_ack_i),
  .timeout_err_o (timeout_err_o),
  .reseed_done_o (reseed_done_o),
  .err_clr_i     (err_clr_i),
  .cnt_clr_i     (cnt_clr_i),
  .hash_cnt_o    (hash_cnt_o),
  .lim_now       (lim_now),
  .wait_now      (wait_now)
);

// File: tb/sim_reseed_sched.sv
module sim_reseed_sched;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0]  prescale = '0;
  logic [15:0] wlimit = '0;
  logic [9:0]  thresh = '0;
  logic hdone = 0, mreq = 0, cclr = 0, eclr = 0, ack = 0;
  logic req, err, done;
  logic [9:0] cnt;

  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { int kind; int at; } ev_t; // kind: 0 req rise, 1 done, 2 error rise
  ev_t expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reseed_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale), .wait_limit_i(wlimit),
    .threshold_i(thresh), .hash_done_i(hdone), .manual_req_i(mreq),
    .cnt_clr_i(cclr), .err_clr_i(eclr), .ent_ack_i(ack),
    .ent_req_o(req), .timeout_err_o(err), .hash_cnt_o(cnt), .reseed_done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at);
    ev_t e;
    e.kind = kind; e.at = at;
    expq.push_back(e);
  endtask

  // monitor: pops expected events as the design produces them
  logic prev_req = 0, prev_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req && !prev_req) pop_cmp(0);
      if (done)             pop_cmp(1);
      if (err && !prev_err) pop_cmp(2);
    end
    prev_req = req;
    prev_err = err;
  end

  task automatic pop_cmp(input int kind);
    ev_t e;
    if (expq.size() == 0) begin
      chk(0, "R2/R3/R4/R10 unexpected event", kind, -1);
    end else begin
      e = expq.pop_front();
      chk(e.kind == kind && e.at == cyc, "R2/R3/R4 event kind/cycle", kind * 100000 + cyc,
          e.kind * 100000 + e.at);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic manual(input int tmo_cycles); // tmo_cycles < 0: no timeout expected
    @(negedge clk);
    expect_ev(0, cyc + 1);
    if (tmo_cycles >= 0) expect_ev(2, cyc + 2 + tmo_cycles);
    mreq = 1;
    @(negedge clk);
    mreq = 0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    expect_ev(1, cyc + 1);
    ack = 1;
    @(negedge clk);
    ack = 0;
    chk(req == 0, "R3 request drops after ack", req, 0);
  endtask

  task automatic pulse_hash();
    @(negedge clk);
    hdone = 1;
    @(negedge clk);
    hdone = 0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    eclr = 1;
    @(negedge clk);
    eclr = 0;
    chk(err == 0, "R9 error cleared", err, 0);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req == 0 && err == 0 && done == 0, "R1 reset outputs", {req, err, done}, 0);
    chk(cnt == 0, "R1 reset count", cnt, 0);

    // R3: ack without a pending request is ignored
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    idle(2);
    chk(req == 0 && done == 0, "R3 stray ack ignored", {req, done}, 0);

    // R2/R3: manual request and handshake
    wlimit = 0;
    manual(-1);
    idle(3);
    chk(req == 1, "R2 request held", req, 1);
    do_ack();
    idle(2);

    // R4: timeout with P=2, L=3
    prescale = 2; wlimit = 3;
    manual(3 * 3);
    idle(14);
    chk(err == 1 && req == 0, "R4 timeout P2 L3", {req, err}, 1);
    // R9: ack and trigger ignored while in error
    @(negedge clk); ack = 1; mreq = 1; @(negedge clk); ack = 0; mreq = 0;
    idle(2);
    chk(err == 1 && req == 0, "R9 error sticky", {req, err}, 1);
    clear_err();
    idle(2);

    // R4: P=0, L=1
    prescale = 0; wlimit = 1;
    manual(1);
    idle(5);
    chk(err == 1, "R4 timeout P0 L1", err, 1);
    clear_err();

    // R6: limit change during a pending request is deferred
    wlimit = 4;
    manual(4);
    wlimit = 1;
    idle(8);
    chk(err == 1, "R6 old limit kept", err, 1);
    clear_err();
    idle(1);
    manual(1);
    idle(5);
    chk(err == 1, "R6 new limit used next time", err, 1);
    clear_err();

    // R5: limit 0 waits indefinitely
    wlimit = 0; prescale = 0;
    idle(1);
    manual(-1);
    idle(150);
    chk(req == 1 && err == 0, "R5 no timeout when limit is 0", {req, err}, 2);
    do_ack();

    // R7: count reaches threshold
    thresh = 3;
    pulse_hash();
    chk(cnt == 1, "R7 count increments", cnt, 1);
    pulse_hash();
    @(negedge clk);
    expect_ev(0, cyc + 2);
    hdone = 1;
    @(negedge clk);
    hdone = 0;
    chk(cnt == 3, "R7 count at threshold", cnt, 3);
    @(negedge clk);
    chk(cnt == 0, "R7 count reset at reseed", cnt, 0);
    do_ack();

    // R10: triggers during a pending request are merged
    manual(-1);
    @(negedge clk); mreq = 1; @(negedge clk); mreq = 0;
    for (int i = 0; i < 3; i++) pulse_hash();
    @(negedge clk);
    chk(cnt == 0, "R10 count consumed while pending", cnt, 0);
    do_ack();
    idle(6);
    chk(req == 0, "R10 no replayed request", req, 0);

    // R8: zero threshold never triggers; clear resets count
    thresh = 0;
    for (int i = 0; i < 5; i++) pulse_hash();
    idle(2);
    chk(cnt == 5 && req == 0, "R8 count without trigger", cnt, 5);
    @(negedge clk); cclr = 1; @(negedge clk); cclr = 0;
    chk(cnt == 0, "R8 clear command", cnt, 0);

    // R7: lowering threshold below an existing count (greater-or-equal)
    for (int i = 0; i < 4; i++) pulse_hash();
    chk(cnt == 4, "R7 count before threshold drop", cnt, 4);
    @(negedge clk);
    t = cyc;
    expect_ev(0, t + 1);
    thresh = 2;
    @(negedge clk);
    chk(cnt == 0, "R7 ge compare consumed count", cnt, 0);
    do_ack();
    idle(4);

    chk(expq.size() == 0, "R2/R3/R4 all expected events seen", expq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule